// File: doc/BRIEF.md
# Privileged Register Access Gate

This block sits between an instruction pipeline and a small bank of privileged registers. Each request carries a 12-bit register address, the current privilege level, a new value and a write mask. The block works out from the address bits alone whether the access is permitted, then returns the register's prior contents and, where the mask is non-zero, writes back a bit-wise merge of old and new data. Plain writes, bit-set and bit-clear operations all become one masked merge. A write sets mask to all ones with the operand as new data. A bit-set uses the operand as the mask with all-ones data. A bit-clear uses the operand as the mask with zero data. A plain read uses a zero mask.

Two banks of `NREG` read-write registers are held inside: one at `M_BASE` that needs machine privilege and one at `S_BASE` that needs supervisor privilege or higher. A window of 32 read-only user counter addresses at `CTR_BASE` returns the externally supplied `ctr_value`. Access to this window is gated per counter by two enable vectors supplied from outside. Results are registered and appear one cycle after the request.

Top module: `csr_gate`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high and low otherwise. While reset is high, `rsp_valid`, `rsp_illegal` and `wr_strobe` are low.
- R2: Privilege codes are user = 0, supervisor = 1, machine = 3. An access is illegal when `cur_priv` is numerically below address bits [9:8].
- R3: An address whose bits [11:10] equal 3 is read-only. An access there with a non-zero mask is illegal. The same access with a zero mask is legal.
- R4: A legal access with a non-zero mask stores `(old & ~mask) | (new & mask)`. It raises `wr_strobe` with this value on `wr_data` and the address on `wr_addr`. A following read returns the stored value.
- R5: A zero mask never raises `wr_strobe` and leaves the register unchanged.
- R6: A legal access returns on `rsp_old` the register contents from before any write made by that same access.
- R7: Counter addresses `CTR_BASE`..`CTR_BASE+31` return `ctr_value`. In user mode, bit address[4:0] of `scnt_en` must be set. In supervisor mode, the same bit of `mcnt_en` must be set. Machine mode always passes. A clear bit makes the access illegal.
- R8: The defined addresses are `M_BASE`..`M_BASE+NREG-1` (defaults 0x340–0x343), `S_BASE`..`S_BASE+NREG-1` (defaults 0x140–0x143) and the counter window (default 0xC00–0xC1F). Any other address is illegal. `NREG` is a power of two, and the bases are aligned to it.
- R9: An illegal access raises `rsp_illegal`, raises no `wr_strobe` and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 12 | Register address |
| req_new | input | XLEN | New data for the merge |
| req_mask | input | XLEN | Write mask; zero means read only |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| scnt_en | input | 32 | Counter enables applied in user mode |
| mcnt_en | input | 32 | Counter enables applied in supervisor mode |
| ctr_value | input | XLEN | Value returned by counter reads |
| rsp_valid | output | 1 | Response valid |
| rsp_illegal | output | 1 | Access refused |
| rsp_old | output | XLEN | Register contents before the access |
| wr_strobe | output | 1 | A merged write took place |
| wr_addr | output | 12 | Address of the responded request |
| wr_data | output | XLEN | Merged value written |

## Verification
A wrong bank entry stays hidden until that address is next read. It then shows on `rsp_old` one cycle after the read request, and it spoils every later merge to that entry. Faults in the legality decode show in the very next response as a wrong `rsp_illegal`. A missed gating of the write then shows as a changed value on the following read of the same register. The bench models the bank behaviourally and compares every response, including idle cycles, so each such fault surfaces within one or two requests.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 32;
  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_MACH  = 2'd3;
endpackage

// File: rtl/csr_gate_check.sv
module csr_gate_check
  import csr_gate_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 4,
  parameter logic [11:0] M_BASE   = 12'h340,
  parameter logic [11:0] S_BASE   = 12'h140,
  parameter logic [11:0] CTR_BASE = 12'hC00
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        priv,
  input  logic [XLEN-1:0]   mask,
  input  logic [CNT_W-1:0]  scnt_en,
  input  logic [CNT_W-1:0]  mcnt_en,
  output logic              hit_m,
  output logic              hit_s,
  output logic              hit_ctr,
  output logic              illegal
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int CIX_W = $clog2(CNT_W);

  logic priv_ok, ro_viol, ctr_ok, any_hit;

  always_comb begin
    hit_m   = addr[ADDR_W-1:IDX_W] == M_BASE[ADDR_W-1:IDX_W];
    hit_s   = addr[ADDR_W-1:IDX_W] == S_BASE[ADDR_W-1:IDX_W];
    hit_ctr = addr[ADDR_W-1:CIX_W] == CTR_BASE[ADDR_W-1:CIX_W];
    any_hit = hit_m | hit_s | hit_ctr;
    priv_ok = priv >= addr[9:8];
    ro_viol = (addr[11:10] == 2'b11) && (|mask);
    case (priv)
      PRIV_USER:  ctr_ok = scnt_en[addr[CIX_W-1:0]];
      PRIV_SUPER: ctr_ok = mcnt_en[addr[CIX_W-1:0]];
      default:    ctr_ok = 1'b1;
    endcase
    illegal = !any_hit || !priv_ok || ro_viol || (hit_ctr && !ctr_ok);
  end
endmodule

// File: rtl/csr_gate_merge.sv
module csr_gate_merge #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] new_val,
  input  logic [XLEN-1:0] mask,
  output logic [XLEN-1:0] merged
);
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    assign merged[b] = mask[b] ? new_val[b] : old_val[b];
  end
endmodule

// File: rtl/csr_gate_bank.sv
module csr_gate_bank #(
  parameter int XLEN = 32,
  parameter int NREG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel_s,
  input  logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] idx,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   rdata
);
  localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int ENTRIES = 2 * NREG;
  localparam int EA_W    = IDX_W + 1;

  logic [XLEN-1:0] regs [ENTRIES];
  logic [EA_W-1:0] ea;

  assign ea    = {sel_s, idx};
  assign rdata = regs[ea];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) regs[i] <= '0;
    end else if (we) begin
      regs[ea] <= wdata;
    end
  end
endmodule

// File: rtl/csr_gate.sv
module csr_gate
  import csr_gate_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 4,
  parameter logic [11:0] M_BASE   = 12'h340,
  parameter logic [11:0] S_BASE   = 12'h140,
  parameter logic [11:0] CTR_BASE = 12'hC00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [11:0]       req_addr,
  input  logic [XLEN-1:0]   req_new,
  input  logic [XLEN-1:0]   req_mask,
  input  logic [1:0]        cur_priv,
  input  logic [31:0]       scnt_en,
  input  logic [31:0]       mcnt_en,
  input  logic [XLEN-1:0]   ctr_value,
  output logic              rsp_valid,
  output logic              rsp_illegal,
  output logic [XLEN-1:0]   rsp_old,
  output logic              wr_strobe,
  output logic [11:0]       wr_addr,
  output logic [XLEN-1:0]   wr_data
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic            hit_m, hit_s, hit_ctr, illegal;
  logic [XLEN-1:0] bank_rd, old_val, merged;
  logic            do_write;

  csr_gate_check #(
    .XLEN(XLEN), .NREG(NREG), .M_BASE(M_BASE), .S_BASE(S_BASE), .CTR_BASE(CTR_BASE)
  ) u_check (
    .addr(req_addr), .priv(cur_priv), .mask(req_mask),
    .scnt_en(scnt_en), .mcnt_en(mcnt_en),
    .hit_m(hit_m), .hit_s(hit_s), .hit_ctr(hit_ctr), .illegal(illegal)
  );

  always_comb begin
    if (hit_m || hit_s) old_val = bank_rd;
    else if (hit_ctr)   old_val = ctr_value;
    else                old_val = '0;
  end

  csr_gate_merge #(.XLEN(XLEN)) u_merge (
    .old_val(old_val), .new_val(req_new), .mask(req_mask), .merged(merged)
  );

  assign do_write = req_valid && !illegal && (|req_mask) && (hit_m || hit_s);

  csr_gate_bank #(.XLEN(XLEN), .NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .we(do_write), .sel_s(hit_s),
    .idx(req_addr[IDX_W-1:0]), .wdata(merged), .rdata(bank_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_old     <= '0;
      wr_strobe   <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_illegal <= req_valid && illegal;
      wr_strobe   <= do_write;
      if (req_valid) begin
        rsp_old <= illegal ? '0 : old_val;
        wr_addr <= req_addr;
        wr_data <= merged;
      end
    end
  end

  // R1: one response per request, one cycle later
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R2: a write only ever happens at sufficient privilege
  assert_write_priv_R2: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> $past(cur_priv) >= wr_addr[9:8]);
  // R3: read-only space is never written
  assert_ro_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> wr_addr[11:10] != 2'b11);
  // R4: unmasked bits of the written value keep their old value
  assert_merge_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    wr_strobe |-> ((wr_data ^ rsp_old) & ~$past(req_mask)) == '0);
  // R5: zero mask never writes
  assert_zero_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mask == '0) |=> !wr_strobe);
  // R9: refused accesses never write
  assert_illegal_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> (rsp_valid && !wr_strobe));
endmodule

// File: tb/tb_csr_gate.sv
module tb_csr_gate;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [11:0] req_addr;
  logic [31:0] req_new, req_mask, ctr_value;
  logic [1:0]  cur_priv;
  logic [31:0] scnt_en, mcnt_en;
  logic        rsp_valid, rsp_illegal, wr_strobe;
  logic [31:0] rsp_old, wr_data;
  logic [11:0] wr_addr;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl_m [4];
  logic [31:0] mdl_s [4];

  always #10 clk = ~clk;

  csr_gate dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_new(req_new), .req_mask(req_mask), .cur_priv(cur_priv),
    .scnt_en(scnt_en), .mcnt_en(mcnt_en), .ctr_value(ctr_value),
    .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .rsp_old(rsp_old),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!rsp_valid && !wr_strobe, "R1", "idle response",
          {30'd0, rsp_valid, wr_strobe}, 32'd0);
    end
  endtask

  task automatic do_req(input logic [11:0] a, input logic [31:0] nv,
                        input logic [31:0] mk, input logic [1:0] pv, input string tag);
    bit in_m, in_s, in_c, gate, ill, we;
    logic [31:0] old, mrg;
    in_m = (a >= 12'h340) && (a <= 12'h343);
    in_s = (a >= 12'h140) && (a <= 12'h143);
    in_c = (a >= 12'hC00) && (a <= 12'hC1F);
    gate = 1'b1;
    if (in_c) begin
      if (pv == 2'd0)      gate = scnt_en[a[4:0]];
      else if (pv == 2'd1) gate = mcnt_en[a[4:0]];
    end
    ill = !(in_m || in_s || in_c) || (int'(pv) < int'(a[9:8])) ||
          ((a[11:10] == 2'b11) && (mk != 0)) || !gate;
    old = in_m ? mdl_m[a[1:0]] : in_s ? mdl_s[a[1:0]] : in_c ? ctr_value : 32'd0;
    mrg = (old & ~mk) | (nv & mk);
    we  = !ill && (mk != 0);
    req_valid = 1'b1; req_addr = a; req_new = nv; req_mask = mk; cur_priv = pv;
    @(negedge clk);
    chk(rsp_valid === 1'b1, tag, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_illegal === ill, tag, "rsp_illegal", {31'd0, rsp_illegal}, {31'd0, ill});
    if (!ill) chk(rsp_old === old, tag, "rsp_old", rsp_old, old);
    chk(wr_strobe === we, tag, "wr_strobe", {31'd0, wr_strobe}, {31'd0, we});
    if (we) begin
      chk(wr_data === mrg, tag, "wr_data", wr_data, mrg);
      chk(wr_addr === a, tag, "wr_addr", {20'd0, wr_addr}, {20'd0, a});
      if (in_m) mdl_m[a[1:0]] = mrg;
      if (in_s) mdl_s[a[1:0]] = mrg;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mdl_m[i] = '0; mdl_s[i] = '0; end
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_new = '0; req_mask = '0;
    cur_priv = 2'd3; scnt_en = '0; mcnt_en = '0; ctr_value = 32'h1234_0007;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !rsp_illegal && !wr_strobe, "R1", "reset outputs",
        {29'd0, rsp_valid, rsp_illegal, wr_strobe}, 32'd0);
    rst = 1'b0;
    idle(2);
    // R4 full write, then R6 old value returned on rewrite
    do_req(12'h340, 32'hA5A5_5A5A, 32'hFFFF_FFFF, 2'd3, "R4");
    do_req(12'h340, 32'h0000_1111, 32'hFFFF_FFFF, 2'd3, "R6");
    // R4 bit-set and bit-clear forms, back to back
    do_req(12'h341, 32'hFFFF_FFFF, 32'h0000_00F0, 2'd3, "R4");
    do_req(12'h341, 32'h0000_0000, 32'h0000_0030, 2'd3, "R4");
    do_req(12'h341, 32'h0, 32'h0, 2'd3, "R6");
    do_req(12'h343, 32'hDEAD_BEEF, 32'h0F0F_0F0F, 2'd3, "R4");
    idle(1);
    // R5 zero mask
    do_req(12'h343, 32'hFFFF_FFFF, 32'h0, 2'd3, "R5");
    do_req(12'h343, 32'h0, 32'h0, 2'd3, "R5");
    // R2 privilege
    do_req(12'h340, 32'h0, 32'h0, 2'd1, "R2");
    do_req(12'h340, 32'h0, 32'h0, 2'd0, "R2");
    do_req(12'h142, 32'h7777_0000, 32'hFFFF_0000, 2'd1, "R2");
    do_req(12'h142, 32'h0, 32'h0, 2'd0, "R2");
    do_req(12'h142, 32'h0, 32'h0, 2'd3, "R2");
    // R9 refused writes leave state
    do_req(12'h340, 32'h5555_5555, 32'hFFFF_FFFF, 2'd0, "R9");
    do_req(12'h142, 32'h1, 32'hFFFF_FFFF, 2'd0, "R9");
    do_req(12'h340, 32'h0, 32'h0, 2'd3, "R9");
    do_req(12'h142, 32'h0, 32'h0, 2'd1, "R9");
    idle(1);
    // R7 counter gating
    do_req(12'hC03, 32'h0, 32'h0, 2'd3, "R7");
    do_req(12'hC03, 32'h0, 32'h0, 2'd0, "R7");
    do_req(12'hC03, 32'h0, 32'h0, 2'd1, "R7");
    scnt_en = 32'h0000_0008; mcnt_en = 32'h8000_0000; ctr_value = 32'h0BAD_F00D;
    do_req(12'hC03, 32'h0, 32'h0, 2'd0, "R7");
    do_req(12'hC03, 32'h0, 32'h0, 2'd1, "R7");
    do_req(12'hC1F, 32'h0, 32'h0, 2'd1, "R7");
    do_req(12'hC1F, 32'h0, 32'h0, 2'd0, "R7");
    // R3 read-only window
    do_req(12'hC03, 32'h1, 32'h1, 2'd3, "R3");
    do_req(12'hC1F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, "R3");
    do_req(12'hC1F, 32'h0, 32'h0, 2'd3, "R3");
    // R8 undefined addresses
    do_req(12'h344, 32'h0, 32'h0, 2'd3, "R8");
    do_req(12'h7C0, 32'h0, 32'h0, 2'd3, "R8");
    do_req(12'hC20, 32'h0, 32'h0, 2'd3, "R8");
    do_req(12'h13F, 32'h1, 32'h1, 2'd3, "R8");
    // final readback of every bank entry
    for (int i = 0; i < 4; i++) begin
      do_req(12'h340 + 12'(i), 32'h0, 32'h0, 2'd3, "R6");
      do_req(12'h140 + 12'(i), 32'h0, 32'h0, 2'd3, "R6");
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule